// File: doc/BRIEF.md
# Page Write Buffer with Protection

This block sits behind the two-wire bus front end of a serial memory. The front end decodes the bus and hands over discrete events. A write transaction opens, a word address byte arrives, data bytes arrive, and a Stop closes the transaction. The block gathers the data bytes of one transaction into a page-sized staging buffer. On the Stop it drains the received bytes into the memory array through a byte write port, one byte per cycle. It then holds a timed busy window that stands in for the cell programming time. While that window is open, it refuses every new request.

The block also decides whether data bytes are acknowledged. A hardware protect input blocks writes to the whole array. A one-time software lock blocks writes to the lowest region of the array. The lock is set by a byte write that the front end flags as aimed at the lock register. A blocked write still has its slave address and word address acknowledged. Its data bytes are not acknowledged, and nothing is committed. The bench models the array as a plain register file.

Top module: `page_write_engine`

## Requirements
- R1: Each accepted data byte is stored at the page offset given by the current pointer, and the pointer then advances. The pointer is the low log2(PAGE_BYTES) bits of the word address, and it wraps inside the page, so a byte arriving after PAGE_BYTES bytes overwrites the one stored at the same offset.
- R2: Only the offsets that received a byte in the transaction are written to the array. Every other address keeps its previous value.
- R3: A Stop that closes a committing transaction raises `busy_o` from the next cycle. `busy_o` stays high for exactly PAGE_BYTES + WRITE_CYCLES cycles. `mem_we_o` is asserted only while `busy_o` is high.
- R4: While `busy_o` is high, `addr_ack_o` and `data_ack_o` are low, and the start, address, data and Stop strobes have no effect.
- R5: While `wp_i` is high, `data_ack_o` is low and no data byte is stored. `addr_ack_o` stays high when the block is idle.
- R6: A transaction opened with `lock_sel_i` high, given a word address and at least one acknowledged data byte, sets the software lock at its Stop. The lock never clears before reset. The word address and data of that transaction are never written to the array.
- R7: Once the lock is set, data bytes for a page below LOCK_BYTES are not acknowledged and not written. Pages at or above LOCK_BYTES remain writable.
- R8: A transaction that stored no byte, including a fully protected one, does not raise `busy_o` at its Stop.
- R9: A data byte that arrives before the word address of its transaction is not acknowledged and is not stored.
- R10: After reset, `busy_o` and `mem_we_o` are low, `addr_ack_o` is high, `data_ack_o` is low and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Hardware write protect, high blocks all writes |
| start_i | input | 1 | Pulse: a write transaction has been addressed to this device |
| lock_sel_i | input | 1 | Qualifies `start_i`: the transaction targets the lock register |
| addr_valid_i | input | 1 | Pulse: word address byte received |
| addr_i | input | AW | Full word address, including block bits |
| data_valid_i | input | 1 | Pulse: data byte received |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | Pulse: Stop condition seen |
| addr_ack_o | output | 1 | Acknowledge slave and word address bytes |
| data_ack_o | output | 1 | Acknowledge the next data byte |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array byte write enable |
| mem_addr_o | output | AW | Array byte write address |
| mem_wdata_o | output | 8 | Array byte write data |

## Verification
The acknowledge outputs are combinational from registered state. The bench therefore reads them at the falling edge right after it drives a strobe, in the same cycle the byte is offered. `busy_o` rises one edge after the sampled Stop. The bench reads it at the next falling edge, then counts falling edges with `busy_o` high and compares the count against PAGE_BYTES + WRITE_CYCLES. The drain writes land during that window, so the array contents are compared only after `busy_o` has fallen. For protected or empty transactions, the bench confirms that `busy_o` is still low one cycle after the Stop, and that the touched addresses are unchanged.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DRAIN = 2'd1,
      SQ_HOLD  = 2'd2
   } sq_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pgb_guard.sv
module pgb_guard #(
   parameter int BW         = 6,
   parameter int LOCK_PAGES = 8,
   parameter bit LOCK_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wp_i,
   input  logic [BW-1:0] page_i,
   input  logic          lock_txn_i,
   input  logic          set_lock_i,
   output logic          locked_o,
   output logic          blocked_o
);
   logic low_page;
   assign low_page = int'(page_i) < LOCK_PAGES;

   generate
      if (LOCK_EN) begin : g_lock
         logic lock_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lock_q <= 1'b0;
            else if (set_lock_i) lock_q <= 1'b1;
         end
         assign locked_o = lock_q;
      end else begin : g_nolock
         assign locked_o = 1'b0;
      end
   endgenerate

   assign blocked_o = wp_i || (!lock_txn_i && locked_o && low_page);
endmodule

// File: rtl/pgb_stage.sv
module pgb_stage #(
   parameter int AW      = 10,
   parameter int PAGE_LW = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  load_i,
   input  logic [AW-1:0]         addr_i,
   input  logic                  push_i,
   input  logic [7:0]            byte_i,
   input  logic [PAGE_LW-1:0]    rd_idx_i,
   output logic [AW-PAGE_LW-1:0] page_o,
   output logic                  any_o,
   output logic                  rd_valid_o,
   output logic [7:0]            rd_data_o
);
   localparam int NB = 1 << PAGE_LW;
   localparam int BW = AW - PAGE_LW;

   logic [BW-1:0]      page_q;
   logic [PAGE_LW-1:0] ptr_q;
   logic [NB-1:0]      mask_q;
   logic [7:0]         slot_q [NB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         ptr_q  <= '0;
         mask_q <= '0;
      end else begin
         if (clear_i) mask_q <= '0;
         if (load_i) begin
            page_q <= addr_i[AW-1:PAGE_LW];
            ptr_q  <= addr_i[PAGE_LW-1:0];
         end else if (push_i) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
         end
      end
   end

   generate
      for (genvar s = 0; s < NB; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       slot_q[s] <= '0;
            else if (push_i && !load_i && ptr_q == PAGE_LW'(s)) slot_q[s] <= byte_i;
         end
      end
   endgenerate

   assign page_o     = page_q;
   assign any_o      = |mask_q;
   assign rd_valid_o = mask_q[rd_idx_i];
   assign rd_data_o  = slot_q[rd_idx_i];
endmodule

// File: rtl/pgb_seq.sv
module pgb_seq
   import pgb_pkg::*;
#(
   parameter int PAGE_LW      = 4,
   parameter int WRITE_CYCLES = 1000000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_i,
   output logic               busy_o,
   output logic               draining_o,
   output logic [PAGE_LW-1:0] idx_o
);
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   sq_state_e          st_q;
   logic [PAGE_LW-1:0] idx_q;
   logic [CW-1:0]      cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         idx_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go_i) begin
               st_q  <= SQ_DRAIN;
               idx_q <= '0;
            end
            SQ_DRAIN: begin
               idx_q <= idx_q + 1'b1;
               if (&idx_q) begin
                  st_q  <= SQ_HOLD;
                  cnt_q <= '0;
               end
            end
            SQ_HOLD: begin
               if (cnt_q == CW'(WRITE_CYCLES - 1)) st_q <= SQ_IDLE;
               else                                cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o     = st_q != SQ_IDLE;
   assign draining_o = st_q == SQ_DRAIN;
   assign idx_o      = idx_q;
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
   parameter int AW           = 10,
   parameter int PAGE_BYTES   = 16,
   parameter int LOCK_BYTES   = 128,
   parameter bit LOCK_EN      = 1'b1,
   parameter int WRITE_CYCLES = 1000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wp_i,
   input  logic          start_i,
   input  logic          lock_sel_i,
   input  logic          addr_valid_i,
   input  logic [AW-1:0] addr_i,
   input  logic          data_valid_i,
   input  logic [7:0]    data_i,
   input  logic          stop_i,
   output logic          addr_ack_o,
   output logic          data_ack_o,
   output logic          busy_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o
);
   import pgb_pkg::*;

   localparam int PAGE_LW    = $clog2(PAGE_BYTES);
   localparam int BW         = AW - PAGE_LW;
   localparam int LOCK_PAGES = LOCK_BYTES / PAGE_BYTES;

   if (!is_pow2(PAGE_BYTES)) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (PAGE_LW >= AW) begin : g_chk_aw
      $error("AW must exceed the page offset width");
   end
   if (LOCK_BYTES % PAGE_BYTES != 0 || LOCK_BYTES > (1 << AW)) begin : g_chk_lock
      $error("LOCK_BYTES must be whole pages inside the array");
   end
   if (WRITE_CYCLES < 1) begin : g_chk_wc
      $error("WRITE_CYCLES must be at least one");
   end

   logic in_txn_q, lock_txn_q, have_addr_q, lock_data_q;
   logic blocked, sw_lock, any_byte, seq_go, set_lock;
   logic draining, rd_valid;
   logic [PAGE_LW-1:0] idx;
   logic [BW-1:0]      page;
   logic [7:0]         rd_data;
   logic take_start, take_addr, take_data, take_stop, push;

   assign take_start = start_i && !busy_o;
   assign take_addr  = addr_valid_i && in_txn_q && !busy_o;
   assign data_ack_o = in_txn_q && have_addr_q && !busy_o && !blocked;
   assign take_data  = data_valid_i && data_ack_o;
   assign take_stop  = stop_i && !busy_o;
   assign push       = take_data && !lock_txn_q;
   assign addr_ack_o = !busy_o;

   assign set_lock = take_stop && in_txn_q && lock_txn_q && lock_data_q;
   assign seq_go   = take_stop && in_txn_q &&
                     (lock_txn_q ? lock_data_q : any_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_txn_q    <= 1'b0;
         lock_txn_q  <= 1'b0;
         have_addr_q <= 1'b0;
         lock_data_q <= 1'b0;
      end else if (take_start) begin
         in_txn_q    <= 1'b1;
         lock_txn_q  <= lock_sel_i;
         have_addr_q <= 1'b0;
         lock_data_q <= 1'b0;
      end else if (take_stop) begin
         in_txn_q    <= 1'b0;
         have_addr_q <= 1'b0;
      end else begin
         if (take_addr) have_addr_q <= 1'b1;
         if (take_data && lock_txn_q) lock_data_q <= 1'b1;
      end
   end

   pgb_guard #(
      .BW(BW), .LOCK_PAGES(LOCK_PAGES), .LOCK_EN(LOCK_EN)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .page_i(page),
      .lock_txn_i(lock_txn_q), .set_lock_i(set_lock),
      .locked_o(sw_lock), .blocked_o(blocked)
   );

   pgb_stage #(.AW(AW), .PAGE_LW(PAGE_LW)) u_stage (
      .clk(clk), .rst_n(rst_n), .clear_i(take_start),
      .load_i(take_addr), .addr_i(addr_i),
      .push_i(push), .byte_i(data_i), .rd_idx_i(idx),
      .page_o(page), .any_o(any_byte),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data)
   );

   pgb_seq #(.PAGE_LW(PAGE_LW), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_i(seq_go),
      .busy_o(busy_o), .draining_o(draining), .idx_o(idx)
   );

   assign mem_we_o    = draining && rd_valid;
   assign mem_addr_o  = {page, idx};
   assign mem_wdata_o = rd_data;
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
   parameter int AW         = 10,
   parameter int LOCK_BYTES = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wp_i,
   input logic          stop_i,
   input logic          addr_ack_o,
   input logic          data_ack_o,
   input logic          busy_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          sw_lock
);
   a_r3_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);
   a_r3_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));
   a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!addr_ack_o && !data_ack_o));
   a_r5_wp_no_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wp_i |-> !data_ack_o);
   a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_lock) |-> sw_lock);
   a_r7_lock_region: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && sw_lock) |-> (int'(mem_addr_o) >= LOCK_BYTES));
endmodule

bind page_write_engine pgb_checker #(.AW(AW), .LOCK_BYTES(LOCK_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .stop_i(stop_i),
   .addr_ack_o(addr_ack_o), .data_ack_o(data_ack_o), .busy_o(busy_o),
   .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .sw_lock(sw_lock)
);

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
   localparam int AW = 10, PB = 16, LB = 128, WC = 24, DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wp = 1'b0, start = 1'b0, lsel = 1'b0, av = 1'b0, dv = 1'b0, stop = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0] data = '0;
   logic addr_ack, data_ack, busy, we;
   logic [AW-1:0] waddr;
   logic [7:0] wdata;
   logic [7:0] arr [DEPTH];
   logic [7:0] expm [DEPTH];
   int errors = 0, checks = 0;

   always #4 clk = ~clk;

   page_write_engine #(.AW(AW), .PAGE_BYTES(PB), .LOCK_BYTES(LB), .LOCK_EN(1'b1),
                       .WRITE_CYCLES(WC)) u_page_write_engine (
      .clk(clk), .rst_n(rst_n), .wp_i(wp), .start_i(start), .lock_sel_i(lsel),
      .addr_valid_i(av), .addr_i(addr), .data_valid_i(dv), .data_i(data),
      .stop_i(stop), .addr_ack_o(addr_ack), .data_ack_o(data_ack), .busy_o(busy),
      .mem_we_o(we), .mem_addr_o(waddr), .mem_wdata_o(wdata));

   always_ff @(posedge clk) if (we) arr[waddr] <= wdata;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base, input int i);
      logic [3:0] off = 4'(int'(base[3:0]) + i);
      return {base[AW-1:4], off};
   endfunction

   task automatic pulse_start(input logic ls);
      start = 1'b1; lsel = ls; @(negedge clk); start = 1'b0; lsel = 1'b0;
   endtask
   task automatic pulse_addr(input logic [AW-1:0] a);
      addr = a; av = 1'b1; @(negedge clk); av = 1'b0;
   endtask
   task automatic pulse_data(input logic [7:0] d, output logic acked);
      data = d; dv = 1'b1; #1 acked = data_ack; @(negedge clk); dv = 1'b0;
   endtask
   task automatic stop_and_count(output int n);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      n = 0;
      while (busy && n < 10000) begin n++; @(negedge clk); end
   endtask

   int mism;
   task automatic compare_all(input string req);
      mism = 0;
      for (int i = 0; i < DEPTH; i++) if (arr[i] !== expm[i]) mism++;
      chk(mism == 0, req, mism, 0);
   endtask

   task automatic page_write(input logic [AW-1:0] base, input int cnt, input int seed_off,
                             input string req, input bit expect_ack);
      logic a;
      int n, nak = 0;
      pulse_start(1'b0);
      pulse_addr(base);
      for (int i = 0; i < cnt; i++) begin
         logic [7:0] d = 8'($urandom_range(0, 255) ^ seed_off);
         pulse_data(d, a);
         if (a !== expect_ack) nak++;
         if (expect_ack) expm[slot_addr(base, i)] = d;
      end
      chk(nak == 0, req, nak, 0);
      stop_and_count(n);
      chk(n == (expect_ack ? PB + WC : 0), expect_ack ? "R3 busy length" : "R8 no busy", n,
          expect_ack ? PB + WC : 0);
      compare_all(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic a;
      int n;
      void'($urandom(32'h5A17));
      for (int i = 0; i < DEPTH; i++) begin arr[i] = '0; expm[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy && !we && addr_ack && !data_ack, "R10 reset outputs",
          {busy, we, addr_ack, data_ack}, 4'b0010);

      // R9 data before word address, R8 empty transaction
      pulse_start(1'b0);
      chk(addr_ack, "R9 addr ack open", addr_ack, 1);
      pulse_data(8'hA5, a);
      chk(!a, "R9 data before address", a, 0);
      stop_and_count(n);
      chk(n == 0, "R8 empty no busy", n, 0);
      compare_all("R9 nothing stored");

      // R1 R2 R3 single byte
      page_write(10'h123, 1, 0, "R2 single byte", 1'b1);
      // R2 partial page
      page_write(10'h205, 3, 7, "R2 partial page", 1'b1);
      // R1 wrap with overwrite
      page_write(10'h30C, 20, 3, "R1 wrap overwrite", 1'b1);
      // R1 full page exactly
      page_write(10'h3A0, 16, 9, "R1 full page", 1'b1);

      // R4 strobes during busy ignored
      pulse_start(1'b0); pulse_addr(10'h150); pulse_data(8'h11, a);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      expm[10'h150] = 8'h11;
      chk(busy && !addr_ack, "R4 addr ack low busy", addr_ack, 0);
      pulse_start(1'b0); pulse_addr(10'h260);
      pulse_data(8'h77, a);
      chk(!a, "R4 data ack low busy", a, 0);
      while (busy) @(negedge clk);
      stop_and_count(n);
      chk(n == 0, "R4 stray stop ignored", n, 0);
      compare_all("R4 busy strobes ignored");

      // R5 hardware protect
      wp = 1'b1;
      pulse_start(1'b0);
      chk(addr_ack, "R5 addr ack under wp", addr_ack, 1);
      pulse_addr(10'h040);
      chk(addr_ack, "R5 word ack under wp", addr_ack, 1);
      page_write(10'h2F0, 4, 1, "R5 wp blocks data", 1'b0);
      wp = 1'b0;

      // random page writes, constrained to idle-state starts
      for (int t = 0; t < 6; t++)
         page_write(AW'($urandom_range(0, DEPTH - 1)), $urandom_range(1, 20), t,
                    "R1 random page", 1'b1);

      // R6 software lock: address and data ignored
      pulse_start(1'b1); pulse_addr(10'h005); pulse_data(8'hEE, a);
      chk(a, "R6 lock data acked", a, 1);
      stop_and_count(n);
      chk(n == PB + WC, "R6 lock busy", n, PB + WC);
      compare_all("R6 lock payload not written");

      // R7 low region blocked, upper writable
      page_write(10'h010, 2, 5, "R7 low region blocked", 1'b0);
      page_write(10'h07F, 1, 5, "R7 top of low region blocked", 1'b0);
      page_write(10'h080, 2, 6, "R7 first free page", 1'b1);
      page_write(10'h090, 3, 8, "R7 upper writable", 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule